// File: doc/BRIEF.md
# Phase Lock Monitor

The block watches two clocks, a reference and the feedback returned from a clock loop, and reports whether they are in phase on a single status flag. Both clocks are brought into a fast system-clock domain through flop synchronizers, and their rising edges are detected there. Each feedback edge is then judged against the nearest reference edge. The judgement is clean when the two edges are no more than a programmable number of system ticks apart, in either order. Otherwise it is an error.

The flag has asymmetric hysteresis. It rises only after a long unbroken run of clean judgements and falls after a short unbroken run of errors. A separate watchdog counts a divided-down copy of the reference. If feedback edges stop arriving, the watchdog clears the flag after a fixed number of divided periods. The flag is a plain, always-driven output and has no enable or reset control other than the block reset. When the reference clock is idle, the flag carries no meaning.

Top module: `phase_lock_monitor`

## Requirements
- R1: While reset is applied, and after it is released, `lock_o` is 0. It stays 0 until the acquisition run of R3 completes.
- R2: Let d be the distance in system ticks between a synchronized feedback rising edge and the nearest synchronized reference rising edge, with either edge first. The feedback cycle is clean when d <= `err_window_i` and an error when d > `err_window_i`. A window of 0 accepts only coincident edges.
- R3: While unlocked, `lock_o` rises on the ACQ_RUN-th (default 32) consecutive clean judgement.
- R4: While unlocked, any error judgement restarts the clean run from zero.
- R5: While locked, `lock_o` falls on the DROP_RUN-th (default 4) consecutive error judgement.
- R6: While locked, a clean judgement restarts the error run from zero. Three errors, one clean cycle and three more errors therefore leave `lock_o` at 1.
- R7: The reference edges are divided by REF_DIV (default 16) into watchdog ticks. TIMEOUT (default 8) ticks with no feedback edge between them clear `lock_o` and both run counters. A feedback edge clears the tick count, and it wins over a tick that arrives in the same cycle.
- R8: `lock_o` is always driven to a known 0 or 1 once reset has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample both monitored clocks |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| fbk_clk_i | input | 1 | Feedback clock from the loop, asynchronous to `clk` |
| err_window_i | input | WIN_W | Largest accepted edge distance, in system ticks |
| lock_o | output | 1 | Lock status flag |

## Verification
A wrong clean-run or error-run count shows at the port as `lock_o` changing one or more feedback periods early or late. That slip appears at the end of the first run in which it matters: at most ACQ_RUN periods, or DROP_RUN periods, after the fault. A mistake in the phase verdict, such as the wrong edge order or an off-by-one at the window boundary, shows only through those counters, so the bench drives offsets of exactly the window and one past it, with each edge first. A watchdog fault that fires early or misses the clear on a feedback edge takes up to REF_DIV*TIMEOUT reference periods to surface. The bench therefore holds the feedback away both for just under and for well over that span.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;

  // One judgement per feedback edge: valid marks the cycle, clean the outcome.
  typedef struct packed {
    logic valid;
    logic clean;
  } verdict_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  localparam int N = STAGES + 1;

  logic [N-1:0] sh_q;
  logic [N-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[N-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // Last synchronizer stage high, extra delay stage still low.
  assign rise_o = sh_q[N-2] & ~sh_q[N-1];

endmodule

// File: rtl/phase_judge.sv
module phase_judge
  import lock_mon_pkg::*;
#(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise_i,
  input  logic             fb_rise_i,
  input  logic [WIN_W-1:0] window_i,
  output verdict_t         verdict_o
);

  localparam int AGE_W = WIN_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q, age_d;
  logic             pend_q, pend_d;
  logic [WIN_W-1:0] wait_q, wait_d;
  logic [AGE_W-1:0] win_ext;

  assign win_ext = {1'b0, window_i};

  // Ticks elapsed since the last reference edge, saturating beyond any window.
  always_comb begin
    if (ref_rise_i)            age_d = '0;
    else if (age_q == AGE_MAX) age_d = age_q;
    else                       age_d = age_q + 1'b1;
  end

  // A lagging feedback edge is judged at once. A leading one opens a wait of up
  // to window ticks for the reference edge.
  always_comb begin
    verdict_o = '0;
    pend_d    = pend_q;
    wait_d    = wait_q;
    if (fb_rise_i) begin
      pend_d = 1'b0;
      if (ref_rise_i || (age_q < win_ext)) begin
        verdict_o.valid = 1'b1;
        verdict_o.clean = 1'b1;
      end else if (window_i == '0) begin
        verdict_o.valid = 1'b1;
      end else begin
        pend_d = 1'b1;
        wait_d = {{(WIN_W-1){1'b0}}, 1'b1};
      end
    end else if (pend_q) begin
      if (ref_rise_i) begin
        verdict_o.valid = 1'b1;
        verdict_o.clean = 1'b1;
        pend_d          = 1'b0;
      end else if (wait_q >= window_i) begin
        verdict_o.valid = 1'b1;
        pend_d          = 1'b0;
      end else begin
        wait_d = wait_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= AGE_MAX;
      pend_q <= 1'b0;
      wait_q <= '0;
    end else begin
      age_q  <= age_d;
      pend_q <= pend_d;
      wait_q <= wait_d;
    end
  end

endmodule

// File: rtl/lock_hysteresis.sv
module lock_hysteresis
  import lock_mon_pkg::*;
#(
  parameter int ACQ_RUN  = 32,
  parameter int DROP_RUN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  verdict_t verdict_i,
  input  logic     trip_i,
  output logic     lock_o
);

  localparam int GOOD_W = $clog2(ACQ_RUN + 1);
  localparam int BAD_W  = $clog2(DROP_RUN + 1);

  logic              lock_q, lock_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic [BAD_W-1:0]  bad_q, bad_d;

  always_comb begin
    lock_d = lock_q;
    good_d = good_q;
    bad_d  = bad_q;
    if (trip_i) begin
      lock_d = 1'b0;
      good_d = '0;
      bad_d  = '0;
    end else if (verdict_i.valid) begin
      if (verdict_i.clean) begin
        bad_d = '0;
        if (!lock_q) begin
          if (good_q == GOOD_W'(ACQ_RUN - 1)) begin
            lock_d = 1'b1;
            good_d = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
      end else begin
        good_d = '0;
        if (lock_q) begin
          if (bad_q == BAD_W'(DROP_RUN - 1)) begin
            lock_d = 1'b0;
            bad_d  = '0;
          end else begin
            bad_d = bad_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
    end else begin
      lock_q <= lock_d;
      good_q <= good_d;
      bad_q  <= bad_d;
    end
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/fb_watchdog.sv
module fb_watchdog #(
  parameter int REF_DIV = 16,
  parameter int TIMEOUT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise_i,
  input  logic fb_rise_i,
  output logic trip_o
);

  localparam int DIV_W = $clog2(REF_DIV + 1);
  localparam int TMO_W = $clog2(TIMEOUT + 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             tick;

  assign tick = ref_rise_i && (div_q == DIV_W'(REF_DIV - 1));

  always_comb begin
    div_d = div_q;
    if (ref_rise_i) begin
      if (tick) div_d = '0;
      else      div_d = div_q + 1'b1;
    end
  end

  always_comb begin
    tmo_d  = tmo_q;
    trip_o = 1'b0;
    if (fb_rise_i) begin
      tmo_d = '0;
    end else if (tick) begin
      if (tmo_q == TMO_W'(TIMEOUT - 1)) begin
        tmo_d  = '0;
        trip_o = 1'b1;
      end else begin
        tmo_d = tmo_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tmo_q <= '0;
    end else begin
      div_q <= div_d;
      tmo_q <= tmo_d;
    end
  end

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import lock_mon_pkg::*;
#(
  parameter int WIN_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ACQ_RUN     = 32,
  parameter int DROP_RUN    = 4,
  parameter int REF_DIV     = 16,
  parameter int TIMEOUT     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_i,
  input  logic             fbk_clk_i,
  input  logic [WIN_W-1:0] err_window_i,
  output logic             lock_o
);

  localparam int NUM_CLK = 2;

  logic [1:0]         rst_pipe_q;
  logic               rst_core_n;
  logic [NUM_CLK-1:0] raw_clk;
  logic [NUM_CLK-1:0] rise;
  logic               ref_rise;
  logic               fb_rise;
  verdict_t           verdict;
  logic               trip;

  // Reset asserts at once and is released on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign raw_clk = {fbk_clk_i, ref_clk_i};

  for (genvar gi = 0; gi < NUM_CLK; gi++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .async_i (raw_clk[gi]),
      .rise_o  (rise[gi])
    );
  end

  assign ref_rise = rise[0];
  assign fb_rise  = rise[1];

  phase_judge #(.WIN_W(WIN_W)) u_judge (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ref_rise_i (ref_rise),
    .fb_rise_i  (fb_rise),
    .window_i   (err_window_i),
    .verdict_o  (verdict)
  );

  fb_watchdog #(.REF_DIV(REF_DIV), .TIMEOUT(TIMEOUT)) u_wdog (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ref_rise_i (ref_rise),
    .fb_rise_i  (fb_rise),
    .trip_o     (trip)
  );

  lock_hysteresis #(.ACQ_RUN(ACQ_RUN), .DROP_RUN(DROP_RUN)) u_hyst (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .verdict_i (verdict),
    .trip_i    (trip),
    .lock_o    (lock_o)
  );

endmodule

// File: rtl/phase_lock_monitor_checker.sv
module phase_lock_monitor_checker (
  input logic clk,
  input logic rst_core_n,
  input logic lock_o,
  input logic v_valid,
  input logic v_clean,
  input logic trip,
  input logic fb_rise
);

  p_reset_low_r1: assert property (@(posedge clk) !rst_core_n |-> !lock_o);

  p_rise_on_clean_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(lock_o) |-> $past(v_valid && v_clean));

  p_error_holds_low_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (v_valid && !v_clean && !lock_o) |=> !lock_o);

  p_fall_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(lock_o) |-> $past((v_valid && !v_clean) || trip));

  p_clean_keeps_lock_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (v_valid && v_clean && lock_o && !trip) |=> lock_o);

  p_trip_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    trip |=> !lock_o);

  p_fb_cancels_trip_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    fb_rise |-> !trip);

  p_known_level_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$isunknown(lock_o));

endmodule

bind phase_lock_monitor phase_lock_monitor_checker u_checker (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .lock_o     (lock_o),
  .v_valid    (verdict.valid),
  .v_clean    (verdict.clean),
  .trip       (trip),
  .fb_rise    (fb_rise)
);

// File: tb/phase_lock_monitor_test.sv
module phase_lock_monitor_test;

  localparam int WIN_W    = 4;
  localparam int ACQ_RUN  = 32;
  localparam int DROP_RUN = 4;
  localparam int REF_DIV  = 16;
  localparam int TIMEOUT  = 8;
  localparam int PERIOD   = 28;  // system cycles per reference period
  localparam int REF_AT   = 7;   // reference rise position inside a period

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ref_clk;
  logic             fbk_clk;
  logic [WIN_W-1:0] win;
  logic             lock;

  int checks = 0;
  int errors = 0;

  // model state, derived from the requirements
  int m_lock, m_good, m_bad, m_div, m_tmo;

  always #10 clk = ~clk;  // 50 MHz

  phase_lock_monitor #(
    .WIN_W(WIN_W), .SYNC_STAGES(2), .ACQ_RUN(ACQ_RUN), .DROP_RUN(DROP_RUN),
    .REF_DIV(REF_DIV), .TIMEOUT(TIMEOUT)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_clk_i    (ref_clk),
    .fbk_clk_i    (fbk_clk),
    .err_window_i (win),
    .lock_o       (lock)
  );

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic void model_judge(input bit clean);
    if (clean) begin
      m_bad = 0;                                // R6
      if (m_lock == 0) begin
        m_good++;
        if (m_good == ACQ_RUN) begin m_lock = 1; m_good = 0; end  // R3
      end
    end else begin
      m_good = 0;                               // R4
      if (m_lock == 1) begin
        m_bad++;
        if (m_bad == DROP_RUN) begin m_lock = 0; m_bad = 0; end   // R5
      end
    end
  endfunction

  function automatic void model_period(input int off, input bit present, input int w);
    bit tick;
    bit trip;
    tick = 0;
    trip = 0;
    if (present && off < 0) m_tmo = 0;
    if (m_div == REF_DIV - 1) begin m_div = 0; tick = 1; end
    else m_div++;
    if (present && off == 0) m_tmo = 0;         // R7 clear wins
    else if (tick) begin
      if (m_tmo == TIMEOUT - 1) begin m_tmo = 0; trip = 1; end
      else m_tmo++;
    end
    if (trip) begin m_lock = 0; m_good = 0; m_bad = 0; end
    if (present && off > 0) m_tmo = 0;
    if (present) model_judge(abs_i(off) <= w);  // R2
  endfunction

  task automatic check_lock(input string tag);
    checks++;
    if (lock !== m_lock[0]) begin               // R8: X or Z also fails
      errors++;
      $display("FAIL %s: lock_o=%b expected %0d", tag, lock, m_lock);
    end
  endtask

  task automatic run_period(input int off, input bit present, input string tag);
    for (int c = 0; c < PERIOD; c++) begin
      @(negedge clk);
      ref_clk = (c >= REF_AT) && (c < REF_AT + 10);
      fbk_clk = present && (c >= REF_AT + off) && (c < REF_AT + 10 + off);
      if (c == PERIOD - 2) begin
        model_period(off, present, int'(win));
        check_lock(tag);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 run limit: cycles=200000 expected earlier completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    int off;
    int w;
    seed_init = $urandom(32'd2024);
    rst_n   = 1'b0;
    ref_clk = 1'b0;
    fbk_clk = 1'b0;
    win     = 4'd3;
    m_lock = 0; m_good = 0; m_bad = 0; m_div = 0; m_tmo = 0;
    repeat (4) @(negedge clk);
    check_lock("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_lock("R1 after reset");

    // R3: acquisition after 32 clean cycles, both edge orders
    for (int i = 0; i < ACQ_RUN; i++) run_period((i % 2 == 0) ? 2 : -3, 1'b1, "R3 acquisition");

    // R2 boundary: exactly window clean, one past it error, both orders
    run_period(4, 1'b1, "R2 lag past window");
    run_period(-3, 1'b1, "R2 lead at window");
    run_period(-4, 1'b1, "R2 lead past window");
    run_period(3, 1'b1, "R2 lag at window");

    // R6: three errors, one clean, three errors keeps lock
    for (int i = 0; i < 3; i++) run_period(5, 1'b1, "R6 first errors");
    run_period(0, 1'b1, "R6 clean break");
    for (int i = 0; i < 3; i++) run_period(-5, 1'b1, "R6 second errors");
    // R5: fourth consecutive error drops lock
    run_period(-6, 1'b1, "R5 drop on fourth error");

    // R4: error restarts acquisition
    for (int i = 0; i < 20; i++) run_period(1, 1'b1, "R4 partial run");
    run_period(6, 1'b1, "R4 breaking error");
    for (int i = 0; i < ACQ_RUN; i++) run_period(-1, 1'b1, "R4 restarted run");

    // R2 window of zero: only coincident edges are clean
    win = 4'd0;
    run_period(-1, 1'b1, "R2 zero window lead");
    run_period(1, 1'b1, "R2 zero window lag");
    run_period(0, 1'b1, "R2 zero window coincident");
    win = 4'd3;
    for (int i = 0; i < ACQ_RUN; i++) run_period(0, 1'b1, "R3 relock");

    // R7: a gap shorter than the timeout, then a cleared count, then a long gap
    for (int i = 0; i < 100; i++) run_period(0, 1'b0, "R7 short gap");
    run_period(0, 1'b1, "R7 feedback clears count");
    for (int i = 0; i < 100; i++) run_period(0, 1'b0, "R7 second short gap");
    for (int i = 0; i < 60; i++) run_period(0, 1'b0, "R7 timeout expiry");

    // constrained random mix
    for (int blk = 0; blk < 12; blk++) begin
      w = int'($urandom % 6);
      win = WIN_W'(w);
      for (int i = 0; i < 50; i++) begin
        if (($urandom % 10) < 8) off = int'($urandom % (2 * w + 1)) - w;
        else                     off = int'($urandom % 13) - 6;
        run_period(off, (($urandom % 40) != 0), "R2 R5 R7 random");
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule